// File: doc/BRIEF.md
# Dual-Source Recirculating Serial Shift Chain

The block is a chain of serial shift segments. Each segment has a configurable number of stages, 64 by default. On every shift, a segment loads one of its two serial inputs into its first stage and moves every other bit one stage toward its output. In the chain, the first segment picks between an external data bit and the bit fed back from the last stage. The mode input makes that choice: low takes new data and high recirculates. Every later segment takes its input from the last stage of the segment to its left. The chain drives the final bit and its complement.

Two cascade styles are available, chosen at elaboration time.
- **Shared:** all segments shift on the same strobe.
- **Rippled:** the system strobe reaches the rightmost segment first. Each segment then passes a registered copy of its strobe, its clock-out, to its left neighbour. This lets a long chain run without one wide strobe net.

In the rippled style, the first segment shifts last. For that reason, the external data bit, the mode bit and the fed-back bit are captured when the system strobe is accepted, and held until the wave arrives. While a wave is still moving, the block reports busy and refuses new strobes. For the same stream of accepted shifts, both styles produce the same bit sequence at the output.

Top module: `srl_chain`

## Requirements
- R1: On each shift, a segment loads its selected serial input into stage 0 and moves each stage i into stage i+1. A bit entered into the chain appears on q_o after N_SEG*SEG_LEN accepted shifts, counting the shift that entered it.
- R2: A segment takes input A when its select is 0 and input B when it is 1. For the first segment, A is data_i, B is the fed-back last-stage bit, and the select is recirc_i.
- R3: A segment whose strobe is low keeps every stage unchanged.
- R4: q_n_o is always the complement of q_o.
- R5: Each segment's clock-out is its shift strobe delayed by one clock.
- R6: In the rippled style, the segment k places from the right shifts exactly k cycles after the rightmost segment, and at most one segment shifts in any cycle.
- R7: In the rippled style, busy_o is high for the N_SEG-1 cycles that follow an accepted strobe. A shift_i pulse during those cycles is ignored. In the shared style, busy_o stays 0.
- R8: In the rippled style, data_i, recirc_i and the last-stage bit are sampled at the accepted strobe. Changes to data_i and recirc_i during the ripple have no effect.
- R9: With recirc_i high, the chain rotates: the bit leaving q_o is re-entered at stage 0.
- R10: rst_ni low asynchronously clears every stage, the capture registers and the ripple state, giving q_o=0, q_n_o=1 and busy_o=0.
- R11: For the same sequence of accepted shifts and inputs, the shared and rippled styles give identical q_o sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_i | input | 1 | System shift strobe |
| data_i | input | 1 | External serial data |
| recirc_i | input | 1 | 1: recirculate last bit, 0: take data_i |
| q_o | output | 1 | Last stage of the rightmost segment |
| q_n_o | output | 1 | Complement of q_o |
| busy_o | output | 1 | Rippled shift still propagating |

## Verification
The bench builds two instances, one rippled and one shared, each with three segments of four stages. The whole chain is therefore 12 bits long, so every bit crosses the output within a few shifts. A long stream of fill, rotation and mixed-mode shifts then covers every stage position and both segment boundaries many times. With three segments, the busy window lasts two cycles. This allows the bench to observe ignored strobes and input changes in the middle of a ripple, and to compare both styles against one arithmetic model bit by bit.

// File: rtl/srl_pkg.sv
package srl_pkg;
  typedef enum logic {
    CASC_SHARED = 1'b0,
    CASC_RIPPLE = 1'b1
  } casc_e;
endpackage

// File: rtl/srl_segment.sv
module srl_segment #(
  parameter int unsigned LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic sel_i,
  input  logic a_i,
  input  logic b_i,
  output logic q_o,
  output logic co_o
);
  logic [LEN-1:0] st_q;
  logic           din;
  logic           co_q;

  assign din = sel_i ? b_i : a_i;

  generate
    if (LEN > 1) begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      st_q <= '0;
        else if (shift_i) st_q <= {st_q[LEN-2:0], din};
      end
      p_move_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> st_q[LEN-1:1] == $past(st_q[LEN-2:0]));
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      st_q <= '0;
        else if (shift_i) st_q <= din;
      end
    end
  endgenerate

  // registered strobe handed to the left neighbour
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) co_q <= 1'b0;
    else         co_q <= shift_i;
  end

  assign q_o  = st_q[LEN-1];
  assign co_o = co_q;

  p_sel_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !sel_i |=> st_q[0] == $past(a_i));
  p_sel_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && sel_i |=> st_q[0] == $past(b_i));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(st_q));
  p_co_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> co_o);
  p_co_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> !co_o);
endmodule

// File: rtl/srl_strobe.sv
module srl_strobe #(
  parameter int unsigned   N_SEG = 2,
  parameter srl_pkg::casc_e CASC = srl_pkg::CASC_RIPPLE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic [N_SEG-1:0] co_i,
  output logic [N_SEG-1:0] stb_o,
  output logic             busy_o
);
  localparam int unsigned LAST = N_SEG - 1;

  generate
    if (CASC == srl_pkg::CASC_RIPPLE && N_SEG > 1) begin : g_ripple
      assign busy_o      = |co_i[LAST:1];
      assign stb_o[LAST] = shift_i & ~busy_o;
      for (genvar i = 0; i < LAST; i++) begin : g_link
        assign stb_o[i] = co_i[i+1];
        p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
          stb_o[i+1] |=> stb_o[i]);
      end
      p_one_seg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(stb_o));
      p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_o[LAST] |=> busy_o);
      p_wave_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        co_i[0] |-> !busy_o);
    end else begin : g_shared
      assign busy_o = 1'b0;
      assign stb_o  = {N_SEG{shift_i}};
      p_shared_co_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> &co_i);
    end
  endgenerate
endmodule

// File: rtl/srl_feed.sv
module srl_feed #(
  parameter int unsigned   N_SEG = 2,
  parameter srl_pkg::casc_e CASC = srl_pkg::CASC_RIPPLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic data_i,
  input  logic recirc_i,
  input  logic last_i,
  output logic sel_o,
  output logic a_o,
  output logic b_o
);
  generate
    if (CASC == srl_pkg::CASC_RIPPLE && N_SEG > 1) begin : g_hold
      logic data_q, mode_q, fb_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          data_q <= 1'b0;
          mode_q <= 1'b0;
          fb_q   <= 1'b0;
        end else if (cap_i) begin
          data_q <= data_i;
          mode_q <= recirc_i;
          fb_q   <= last_i;
        end
      end
      assign sel_o = mode_q;
      assign a_o   = data_q;
      assign b_o   = fb_q;

      p_cap_fb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_i |=> fb_q == $past(last_i));
      p_cap_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_i |=> $stable({data_q, mode_q, fb_q}));
    end else begin : g_direct
      assign sel_o = recirc_i;
      assign a_o   = data_i;
      assign b_o   = last_i;
      p_direct_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_i |-> ##0 (recirc_i ? (b_o == last_i) : (a_o == data_i)));
    end
  endgenerate
endmodule

// File: rtl/srl_chain.sv
module srl_chain #(
  parameter int unsigned    N_SEG   = 2,
  parameter int unsigned    SEG_LEN = 64,
  parameter srl_pkg::casc_e CASC    = srl_pkg::CASC_RIPPLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic data_i,
  input  logic recirc_i,
  output logic q_o,
  output logic q_n_o,
  output logic busy_o
);
  localparam int unsigned LAST = N_SEG - 1;

  logic [N_SEG-1:0] seg_q;
  logic [N_SEG-1:0] seg_co;
  logic [N_SEG-1:0] stb;
  logic             f_sel, f_a, f_b;

  srl_strobe #(.N_SEG(N_SEG), .CASC(CASC)) i_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(shift_i),
    .co_i   (seg_co),
    .stb_o  (stb),
    .busy_o (busy_o)
  );

  srl_feed #(.N_SEG(N_SEG), .CASC(CASC)) i_feed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (stb[LAST]),
    .data_i  (data_i),
    .recirc_i(recirc_i),
    .last_i  (seg_q[LAST]),
    .sel_o   (f_sel),
    .a_o     (f_a),
    .b_o     (f_b)
  );

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    logic s_sel, s_a, s_b;
    if (i == 0) begin : g_head
      assign s_sel = f_sel;
      assign s_a   = f_a;
      assign s_b   = f_b;
    end else begin : g_body
      assign s_sel = 1'b0;
      assign s_a   = seg_q[i-1];
      assign s_b   = 1'b0;
    end
    srl_segment #(.LEN(SEG_LEN)) i_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(stb[i]),
      .sel_i  (s_sel),
      .a_i    (s_a),
      .b_i    (s_b),
      .q_o    (seg_q[i]),
      .co_o   (seg_co[i])
    );
  end

  assign q_o   = seg_q[LAST];
  assign q_n_o = ~seg_q[LAST];

  p_idle_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb[LAST] |=> $stable(q_o));
  p_cmp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_n_o != q_o);
endmodule

// File: tb/test_srl_chain.sv
module test_srl_chain;
  localparam int NS = 3;
  localparam int SL = 4;
  localparam int NL = NS * SL;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shift_rp = 1'b0, shift_sh = 1'b0;
  logic data = 1'b0, recirc = 1'b0;
  logic q_rp, qn_rp, busy_rp, q_sh, qn_sh, busy_sh;
  logic [NL-1:0] m = '0;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  srl_chain #(.N_SEG(NS), .SEG_LEN(SL), .CASC(srl_pkg::CASC_RIPPLE)) i_srl_chain (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift_rp), .data_i(data),
    .recirc_i(recirc), .q_o(q_rp), .q_n_o(qn_rp), .busy_o(busy_rp));

  srl_chain #(.N_SEG(NS), .SEG_LEN(SL), .CASC(srl_pkg::CASC_SHARED)) i_srl_chain_sh (
    .clk_i(clk), .rst_ni(rst_ni), .shift_i(shift_sh), .data_i(data),
    .recirc_i(recirc), .q_o(q_sh), .q_n_o(qn_sh), .busy_o(busy_sh));

  task automatic chk(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, q_rp, m[NL-1]);
    chk(req, q_sh, m[NL-1]);
    chk("R4", qn_rp, ~q_rp);
    chk("R4", qn_sh, ~q_sh);
    chk("R7 shared busy", busy_sh, 1'b0);
  endtask

  // one accepted shift on both; optional stray strobe and input flip mid-ripple
  task automatic step(logic d, logic r, bit stray, string req);
    logic inj;
    @(negedge clk);
    data = d; recirc = r; shift_rp = 1'b1; shift_sh = 1'b1;
    inj = r ? m[NL-1] : d;
    m = {m[NL-2:0], inj};
    @(negedge clk);
    shift_sh = 1'b0;
    shift_rp = stray;
    data = ~d; recirc = ~r;          // R8: must not matter
    chk_out(req);
    chk("R7 busy1", busy_rp, 1'b1);
    @(negedge clk);
    shift_rp = 1'b0;
    chk("R7 busy2", busy_rp, 1'b1);
    chk("R7 stray ignored", q_rp, m[NL-1]);
    @(negedge clk);
    chk("R7 busy end", busy_rp, 1'b0);
    chk("R11", q_rp, q_sh);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 q", q_rp, 1'b0);
    chk("R10 qn", qn_rp, 1'b1);
    chk("R10 busy", busy_rp, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3 idle", q_rp, 1'b0);

    // fill with a pattern: entry, latency and boundaries (R1, R2)
    for (int i = 0; i < 40; i++)
      step(logic'(((i * 37) >> 3) & 1) ^ logic'(i % 5 == 0), 1'b0, 1'b0, "R1");

    // rotation: full rotations return the same stream (R9)
    for (int i = 0; i < 3 * NL; i++) step(1'b0, 1'b1, 1'b0, "R9");

    // mixed mode with stray strobes during ripple (R2, R6, R7, R8)
    for (int i = 0; i < 60; i++)
      step(logic'(i & 1), logic'((i / 3) & 1), logic'(i % 4 == 1), "R2");

    // idle cycles: no shift, outputs hold (R3)
    repeat (5) @(negedge clk);
    chk_out("R3");

    // asynchronous reset mid-run (R10)
    @(negedge clk);
    rst_ni = 1'b0;
    #3;
    chk("R10 q async", q_rp, 1'b0);
    chk("R10 qn async", qn_sh, 1'b1);
    m = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NL + 4; i++) step(logic'(i % 3 == 0), 1'b0, 1'b0, "R10 after");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule